// File: doc/BRIEF.md
# Post-Update Load Execution Unit

This unit executes integer loads in which memory is read at the base register's value as it was before the instruction. The base is then advanced by an offset and written back. The offset comes either from a second register (indexed form) or from a signed 16-bit immediate (displacement form). The unit takes one decoded operation at a time. That operation carries the access size, an extension selector, the form, the target and base register numbers, and the operand values.

For each valid operation the unit issues a single memory read. It then waits for the response and shapes the returned bytes to 64 bits. Finally it returns both register write-backs in one done cycle: the loaded value and the updated base. An operation whose base register is 0, or whose base equals its target, is an invalid form. It is reported on a flag and produces neither a memory access nor a write-back. No other architectural state is touched.

Top module: `pu_load_unit`

## Requirements
- R1: The memory request address equals the base operand value latched at acceptance, with no offset added. The request size field carries the access size encoded as 0 = byte, 1 = halfword, 2 = word, 3 = doubleword.
- R2: In the indexed form (op_indexed = 1) the updated base equals base + index, wrapping modulo 2^64 with no overflow signal.
- R3: In the displacement form (op_indexed = 0) the updated base equals base + the sign-extended 16-bit displacement, and the index operand has no effect.
- R4: A byte load returns response bits 7:0 in result bits 7:0 with all upper bits zero, whatever the extension selector says.
- R5: A halfword load returns response bits 15:0. Bits 63:16 are zero when op_signed = 0 and copies of bit 15 when op_signed = 1.
- R6: A word load returns response bits 31:0. Bits 63:32 are zero when op_signed = 0 and copies of bit 31 when op_signed = 1.
- R7: A doubleword load returns all 64 response bits unchanged for either extension selector.
- R8: When the base register number is 0 or equals the target register number, bad_form pulses for exactly one cycle, the cycle after acceptance. No memory request and no done pulse follow, and op_ready stays high.
- R9: done pulses for one cycle, the cycle after the response is sampled. In that cycle the load port carries the target register number and the base port carries the base register number, both with their data.
- R10: The memory request holds its valid, address and size stable until mem_req_ready is seen, and op_ready is low from acceptance until done.
- R11: Response bits above the access size are ignored.
- R12: After reset, op_ready is high and mem_req_valid, done and bad_form are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit idle, operation accepted when op_valid is high |
| op_size | input | 2 | Access size (0 byte, 1 half, 2 word, 3 double) |
| op_signed | input | 1 | 1 selects sign extension |
| op_indexed | input | 1 | 1 selects index register offset, 0 selects displacement |
| op_dest | input | 5 | Target register number |
| op_base | input | 5 | Base register number |
| base_val | input | 64 | Base register value |
| index_val | input | 64 | Index register value |
| disp | input | 16 | Signed displacement |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 64 | Read address |
| mem_req_size | output | 2 | Read size |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data, right-aligned |
| done | output | 1 | Both write-backs valid this cycle |
| bad_form | output | 1 | Invalid-form pulse |
| ld_wb_reg | output | 5 | Load result register number |
| ld_wb_data | output | 64 | Load result |
| base_wb_reg | output | 5 | Updated-base register number |
| base_wb_data | output | 64 | Updated base value |

## Verification
The memory request is due one cycle after acceptance. done and both write-back ports are due one cycle after the cycle in which mem_rsp_valid is sampled. bad_form is due one cycle after an invalid operation is accepted. The bench drives inputs on the falling edge and samples on the falling edge after the rising edge that must produce each result. This puts every check exactly in the due cycle, and a further check in the following cycle confirms that the pulses last only one cycle.

// File: rtl/pu_load_pkg.sv
package pu_load_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } unit_state_e;
endpackage

// File: rtl/pu_form_check.sv
module pu_form_check #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] base_reg,
    input  logic [REG_W-1:0] dest_reg,
    output logic             invalid
);
    // base register zero or aliasing the target makes the form illegal
    always_comb begin
        invalid = (base_reg == '0) || (base_reg == dest_reg);
    end
endmodule

// File: rtl/pu_base_adder.sv
module pu_base_adder #(
    parameter int XLEN   = 64,
    parameter int DISP_W = 16
) (
    input  logic [XLEN-1:0]   base,
    input  logic [XLEN-1:0]   index,
    input  logic [DISP_W-1:0] disp,
    input  logic              indexed,
    output logic [XLEN-1:0]   sum
);
    localparam int EXT_W = XLEN - DISP_W;

    logic [XLEN-1:0] offset;

    always_comb begin
        if (indexed) offset = index;
        else         offset = {{EXT_W{disp[DISP_W-1]}}, disp};
        sum = base + offset;   // wraps modulo 2^XLEN
    end
endmodule

// File: rtl/pu_load_shaper.sv
module pu_load_shaper
    import pu_load_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  acc_size_e       size,
    input  logic            sgn,
    input  logic [XLEN-1:0] raw,
    output logic [XLEN-1:0] shaped
);
    localparam int B_W = 8;
    localparam int H_W = 16;
    localparam int W_W = 32;

    always_comb begin
        unique case (size)
            SZ_BYTE: shaped = {{(XLEN-B_W){1'b0}}, raw[B_W-1:0]};
            SZ_HALF: shaped = {{(XLEN-H_W){sgn & raw[H_W-1]}}, raw[H_W-1:0]};
            SZ_WORD: shaped = {{(XLEN-W_W){sgn & raw[W_W-1]}}, raw[W_W-1:0]};
            default: shaped = raw;
        endcase
    end
endmodule

// File: rtl/pu_load_unit.sv
module pu_load_unit
    import pu_load_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int REG_W  = 5,
    parameter int DISP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    output logic              op_ready,
    input  logic [1:0]        op_size,
    input  logic              op_signed,
    input  logic              op_indexed,
    input  logic [REG_W-1:0]  op_dest,
    input  logic [REG_W-1:0]  op_base,
    input  logic [XLEN-1:0]   base_val,
    input  logic [XLEN-1:0]   index_val,
    input  logic [DISP_W-1:0] disp,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [XLEN-1:0]   mem_req_addr,
    output logic [1:0]        mem_req_size,
    input  logic              mem_rsp_valid,
    input  logic [XLEN-1:0]   mem_rsp_data,
    output logic              done,
    output logic              bad_form,
    output logic [REG_W-1:0]  ld_wb_reg,
    output logic [XLEN-1:0]   ld_wb_data,
    output logic [REG_W-1:0]  base_wb_reg,
    output logic [XLEN-1:0]   base_wb_data
);
    typedef struct packed {
        unit_state_e      st;
        acc_size_e        size;
        logic             sgn;
        logic [REG_W-1:0] dest;
        logic [REG_W-1:0] breg;
        logic [XLEN-1:0]  addr;
        logic [XLEN-1:0]  sum;
        logic [XLEN-1:0]  ld;
        logic             done;
        logic             bad;
    } regs_t;

    regs_t           r_q, r_d;
    logic            form_bad;
    logic [XLEN-1:0] new_base;
    logic [XLEN-1:0] shaped;

    pu_form_check #(.REG_W(REG_W)) u_check (
        .base_reg (op_base),
        .dest_reg (op_dest),
        .invalid  (form_bad)
    );

    pu_base_adder #(.XLEN(XLEN), .DISP_W(DISP_W)) u_adder (
        .base    (base_val),
        .index   (index_val),
        .disp    (disp),
        .indexed (op_indexed),
        .sum     (new_base)
    );

    pu_load_shaper #(.XLEN(XLEN)) u_shape (
        .size   (r_q.size),
        .sgn    (r_q.sgn),
        .raw    (mem_rsp_data),
        .shaped (shaped)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.bad  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (op_valid) begin
                    r_d.size = acc_size_e'(op_size);
                    r_d.sgn  = op_signed;
                    r_d.dest = op_dest;
                    r_d.breg = op_base;
                    if (form_bad) begin
                        r_d.bad = 1'b1;
                    end else begin
                        r_d.addr = base_val;
                        r_d.sum  = new_base;
                        r_d.st   = ST_REQ;
                    end
                end
            end
            ST_REQ: begin
                if (mem_req_ready) r_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    r_d.ld   = shaped;
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign op_ready      = (r_q.st == ST_IDLE);
    assign mem_req_valid = (r_q.st == ST_REQ);
    assign mem_req_addr  = r_q.addr;
    assign mem_req_size  = r_q.size;
    assign done          = r_q.done;
    assign bad_form      = r_q.bad;
    assign ld_wb_reg     = r_q.dest;
    assign ld_wb_data    = r_q.ld;
    assign base_wb_reg   = r_q.breg;
    assign base_wb_data  = r_q.sum;

    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=>
            mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_size));

    p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !op_ready);

    p_bad_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bad_form |-> !done && !mem_req_valid && op_ready);

    p_bad_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bad_form |-> $past(op_valid && op_ready));

    p_done_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_rsp_valid));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_byte_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done && (mem_req_size == SZ_BYTE) |-> (ld_wb_data[XLEN-1:8] == '0));
endmodule

// File: tb/pu_load_unit_test.sv
module pu_load_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_ready;
    logic [1:0]  op_size = '0;
    logic        op_signed = 1'b0;
    logic        op_indexed = 1'b0;
    logic [4:0]  op_dest = '0;
    logic [4:0]  op_base = '0;
    logic [63:0] base_val = '0;
    logic [63:0] index_val = '0;
    logic [15:0] disp = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [63:0] mem_req_addr;
    logic [1:0]  mem_req_size;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        done;
    logic        bad_form;
    logic [4:0]  ld_wb_reg;
    logic [63:0] ld_wb_data;
    logic [4:0]  base_wb_reg;
    logic [63:0] base_wb_data;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    pu_load_unit uut (.*);

    typedef struct packed {
        logic [1:0]  size;
        logic        sgn;
        logic        idx;
        logic [63:0] base;
        logic [63:0] index;
        logic [15:0] dsp;
        logic [63:0] mem;
        logic [63:0] exp_ld;
        logic [63:0] exp_base;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        // R4 byte, R2 indexed, R11 upper response junk ignored
        '{2'd0, 1'b0, 1'b1, 64'h1000, 64'h10, 16'h0,
          64'hFFFF_FFFF_FFFF_FF85, 64'h85, 64'h1010},
        // R4 signed flag ignored for byte, R3 negative displacement, index ignored
        '{2'd0, 1'b1, 1'b0, 64'h1000, 64'hDEAD, 16'hFFF0,
          64'h0123_4567_89AB_CDA5, 64'hA5, 64'h0FF0},
        // R5 zero-extended half
        '{2'd1, 1'b0, 1'b1, 64'h2000, 64'h2, 16'h0,
          64'h1234_5678_9ABC_8001, 64'h8001, 64'h2002},
        // R5 sign-extended half, R2 wrap modulo 2^64
        '{2'd1, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h2, 16'h0,
          64'h1234_5678_9ABC_8001, 64'hFFFF_FFFF_FFFF_8001, 64'h1},
        // R5 sign-extended positive half, R3 positive displacement
        '{2'd1, 1'b1, 1'b0, 64'h3000, 64'hBEEF, 16'h0004,
          64'hAAAA_AAAA_AAAA_7FFE, 64'h7FFE, 64'h3004},
        // R6 zero-extended word
        '{2'd2, 1'b0, 1'b1, 64'h4000, 64'h8, 16'h0,
          64'hDEAD_BEEF_8765_4321, 64'h8765_4321, 64'h4008},
        // R6 sign-extended word, R3 most negative displacement
        '{2'd2, 1'b1, 1'b0, 64'h10000, 64'h0, 16'h8000,
          64'hDEAD_BEEF_8765_4321, 64'hFFFF_FFFF_8765_4321, 64'h8000},
        // R6 sign-extended positive word
        '{2'd2, 1'b1, 1'b1, 64'h6000, 64'h0, 16'h0,
          64'hFFFF_FFFF_1234_5678, 64'h1234_5678, 64'h6000},
        // R7 doubleword, R2 negative index
        '{2'd3, 1'b1, 1'b1, 64'h5000, 64'hFFFF_FFFF_FFFF_FFF8, 16'h0,
          64'hF0E1_D2C3_B4A5_9687, 64'hF0E1_D2C3_B4A5_9687, 64'h4FF8}
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic offer(input vec_t v, input logic [4:0] dst, input logic [4:0] brg);
        @(negedge clk);
        op_size = v.size; op_signed = v.sgn; op_indexed = v.idx;
        op_dest = dst; op_base = brg; base_val = v.base; index_val = v.index;
        disp = v.dsp; op_valid = 1'b1;
        chk(op_ready == 1'b1, "R10 ready when idle", 64'(op_ready), 64'h1);
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic run_vec(input vec_t v, input int stall, input string tag);
        offer(v, 5'd3, 5'd4);
        chk(mem_req_valid == 1'b1, {tag, " R1 request issued"}, 64'(mem_req_valid), 64'h1);
        chk(mem_req_addr == v.base, {tag, " R1 address is old base"}, mem_req_addr, v.base);
        chk(mem_req_size == v.size, {tag, " R1 size code"}, 64'(mem_req_size), 64'(v.size));
        if (stall > 0) begin
            mem_req_ready = 1'b0;
            for (int i = 0; i < stall; i++) begin
                @(negedge clk);
                chk(mem_req_valid && mem_req_addr == v.base && mem_req_size == v.size,
                    "R10 request held", mem_req_addr, v.base);
                chk(op_ready == 1'b0, "R10 busy", 64'(op_ready), 64'h0);
            end
            mem_req_ready = 1'b1;
        end
        @(negedge clk);
        chk(mem_req_valid == 1'b0, "R10 request dropped after ready", 64'(mem_req_valid), 64'h0);
        if (stall > 0) begin
            @(negedge clk);
            chk(done == 1'b0 && op_ready == 1'b0, "R9 no done without response",
                64'(done), 64'h0);
        end
        mem_rsp_valid = 1'b1; mem_rsp_data = v.mem;
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_data = '1;
        chk(done == 1'b1, {tag, " R9 done"}, 64'(done), 64'h1);
        chk(ld_wb_data == v.exp_ld, {tag, " R4 R5 R6 R7 R11 load data"}, ld_wb_data, v.exp_ld);
        chk(base_wb_data == v.exp_base, {tag, " R2 R3 updated base"}, base_wb_data, v.exp_base);
        chk(ld_wb_reg == 5'd3 && base_wb_reg == 5'd4, {tag, " R9 register numbers"},
            {ld_wb_reg, base_wb_reg}, {5'd3, 5'd4});
        chk(op_ready == 1'b1, "R10 ready again with done", 64'(op_ready), 64'h1);
        @(negedge clk);
        chk(done == 1'b0, "R9 done is one pulse", 64'(done), 64'h0);
    endtask

    task automatic run_bad(input logic [4:0] dst, input logic [4:0] brg, input string tag);
        offer(VECS[0], dst, brg);
        chk(bad_form == 1'b1, {tag, " R8 flag"}, 64'(bad_form), 64'h1);
        chk(mem_req_valid == 1'b0 && done == 1'b0, {tag, " R8 no access or write-back"},
            64'({mem_req_valid, done}), 64'h0);
        chk(op_ready == 1'b1, {tag, " R8 stays ready"}, 64'(op_ready), 64'h1);
        @(negedge clk);
        chk(bad_form == 1'b0 && mem_req_valid == 1'b0 && done == 1'b0,
            {tag, " R8 one pulse, still quiet"}, 64'({bad_form, mem_req_valid, done}), 64'h0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        chk(op_ready == 1'b1 && mem_req_valid == 1'b0 && done == 1'b0 && bad_form == 1'b0,
            "R12 reset state", 64'({op_ready, mem_req_valid, done, bad_form}), 64'h8);
        rst_n = 1'b1;
        @(negedge clk);
        chk(op_ready == 1'b1 && mem_req_valid == 1'b0, "R12 idle after reset",
            64'({op_ready, mem_req_valid}), 64'h2);

        for (int k = 0; k < NV; k++) run_vec(VECS[k], 0, $sformatf("vec%0d", k));

        // stalled request then delayed response
        run_vec(VECS[6], 3, "stall");

        run_bad(5'd3, 5'd0, "base zero");
        run_bad(5'd7, 5'd7, "base equals target");
        // a valid op right after an invalid one still works
        run_vec(VECS[8], 0, "after bad");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule